// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block guards a microcontroller against a hung program. It sits on the byte-wide special-function-register write bus. Software arms it by writing a two-byte key to the service register: 0x1E first, then 0xE1. From that point it counts machine cycles. Each further copy of the same key sets the count back to zero. If the count reaches the selected limit before the next key arrives, the block drives a reset request for a fixed number of clocks. It then returns to its disarmed state.

A second register holds a 3-bit timeout selector n. The limit is 2^(BASE_EXP+n)−1 machine cycles, which is 16383 to 2097151 cycles with the default BASE_EXP of 14. The selector is copied into the running counter only when a key is accepted. A build option removes the selector, and the limit is then fixed at 2^BASE_EXP−1. The counter advances only in clock cycles where the machine-cycle enable is high. With one enable every 12 oscillator clocks at 12 MHz, the shortest limit is about 16.4 ms.

The main state machine has three states. OFF is disarmed. RUN is counting. FIRE drives the reset pulse. Its transitions are: ARM (OFF to RUN on an accepted key), SERVICE (RUN to RUN on an accepted key, count cleared), EXPIRE (RUN to FIRE when the count reaches the limit) and RELEASE (FIRE to OFF after the pulse). The key state machine has two states. KY_IDLE waits for the first key byte. KY_HALF holds after 0x1E and waits for 0xE1.

Top module: `keyed_watchdog`

## Requirements
- R1: A write of 0x1E to the service register (address KEY_ADDR, default 0xA6), followed by a write of 0xE1 as the next write to that register, is an accepted key. The first accepted key after reset arms the watchdog.
- R2: In KY_HALF, a write of any value other than 0xE1 or 0x1E to the service register cancels the pending key. A write of 0x1E in KY_HALF keeps the key half-complete. A write of 0xE1 that does not follow 0x1E does nothing. Writes to other addresses do not disturb a pending key.
- R3: While armed, the count advances only in cycles where mc_en is high. wdt_rst_o rises on the clock edge that brings the count to 2^(BASE_EXP+n)−1 enabled cycles. The edge that accepts the key is not counted.
- R4: An accepted key while armed clears the count. The next timeout is then measured from that key, as in R3.
- R5: The low 3 bits of a write to the selector register (address PRESC_ADDR, default 0xA7) give n. A new n takes effect only when the next key is accepted.
- R6: With HAS_PRESC = 0, n is always 0, whatever was written to the selector register.
- R7: wdt_rst_o is high for exactly PULSE_LEN consecutive clocks. The block then returns to OFF, and no further pulse occurs until a new key is accepted.
- R8: Once armed, no bus write stops the watchdog. A key completed while the pulse is active is ignored.
- R9: After the asynchronous reset, the watchdog is disarmed and wdt_rst_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| sfr_we | input | 1 | Register write strobe, one clock per write |
| sfr_addr | input | ADDR_W | Register write address |
| sfr_wdata | input | 8 | Register write data |
| mc_en | input | 1 | Machine-cycle enable, high for one clock per machine cycle |
| wdt_rst_o | output | 1 | Registered reset request pulse |

## Verification
The bench builds two copies of the block with BASE_EXP = 4 and PULSE_LEN = 3. One copy has the selector and the other has HAS_PRESC = 0. The small exponent brings the shortest limit down to 15 cycles and the longest to 2047 cycles. This puts the exact edge of expiry, restarts in the middle of a count, deferred selector changes and keys written during the pulse within a short run. Holding mc_en high on every clock makes each expected edge a plain count of clocks.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_FIRE = 2'd2
    } wd_state_e;

    typedef enum logic {
        KY_IDLE = 1'b0,
        KY_HALF = 1'b1
    } key_state_e;

    localparam logic [7:0] KEY_FIRST  = 8'h1E;
    localparam logic [7:0] KEY_SECOND = 8'hE1;
endpackage

// File: rtl/kwdt_key_fsm.sv
module kwdt_key_fsm
    import kwdt_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR = 'hA6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              key_ok
);
    key_state_e st_q, st_d;
    logic       hit;
    logic       key_wr;

    assign key_wr = wr_en && (wr_addr == KEY_ADDR);

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        if (key_wr) begin
            unique case (st_q)
                KY_IDLE: if (wr_data == KEY_FIRST) st_d = KY_HALF;
                KY_HALF: begin
                    if (wr_data == KEY_SECOND) begin
                        st_d = KY_IDLE;
                        hit  = 1'b1;
                    end else if (wr_data == KEY_FIRST) begin
                        st_d = KY_HALF;
                    end else begin
                        st_d = KY_IDLE;
                    end
                end
                default: st_d = KY_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= KY_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) key_ok <= 1'b0;
        else        key_ok <= hit;
    end

    // R1: an accepted key always follows a second-byte write to the service register
    p_key_after_second_r1: assert property (@(posedge clk) disable iff (!rst_n)
        key_ok |-> $past(wr_en && wr_addr == KEY_ADDR && wr_data == KEY_SECOND));

    // R2: the key is only accepted from the half-complete state
    p_key_needs_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        key_ok |-> $past(st_q == KY_HALF));
endmodule

// File: rtl/kwdt_timeout_sel.sv
module kwdt_timeout_sel #(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] PRESC_ADDR = 'hA7,
    parameter int                SEL_W      = 3,
    parameter bit                HAS_PRESC  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              load,
    output logic [SEL_W-1:0]  sel_o
);
    logic [SEL_W-1:0] presc;

    generate
        if (HAS_PRESC) begin : g_presc
            logic [SEL_W-1:0] presc_q;
            logic             unused_hi;
            assign unused_hi = ^wr_data[7:SEL_W];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                presc_q <= '0;
                else if (wr_en && wr_addr == PRESC_ADDR)   presc_q <= wr_data[SEL_W-1:0];
            end
            assign presc = presc_q;
        end else begin : g_fixed
            logic unused_bus;
            assign unused_bus = ^{wr_en, wr_addr, wr_data};
            assign presc = '0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sel_o <= '0;
        else if (load) sel_o <= presc;
    end
endmodule

// File: rtl/kwdt_core.sv
module kwdt_core
    import kwdt_pkg::*;
#(
    parameter int BASE_EXP  = 14,
    parameter int SEL_W     = 3,
    parameter int CNT_W     = 21,
    parameter int PULSE_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mc_en,
    input  logic             svc,
    input  logic [SEL_W-1:0] sel,
    output logic             load,
    output logic             rst_req
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_nx, limit;
    logic [PW-1:0]    pls_q;
    logic             svc_ok;
    int               shamt;

    assign shamt  = CNT_W - BASE_EXP - int'(sel);
    assign limit  = {CNT_W{1'b1}} >> shamt;
    assign cnt_nx = cnt_q + 1'b1;
    assign svc_ok = svc && (state_q != WD_FIRE);
    assign load   = svc_ok;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF:  if (svc_ok) state_d = WD_RUN;
            WD_RUN:  if (!svc_ok && mc_en && cnt_nx == limit) state_d = WD_FIRE;
            WD_FIRE: if (pls_q == PW'(PULSE_LEN - 1)) state_d = WD_OFF;
            default: state_d = WD_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            cnt_q <= '0;
        else if (state_d != WD_RUN || svc_ok)  cnt_q <= '0;
        else if (mc_en)                        cnt_q <= cnt_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 pls_q <= '0;
        else if (state_q == WD_FIRE) pls_q <= pls_q + 1'b1;
        else                         pls_q <= '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= (state_d == WD_FIRE);
    end

    // R3: without an enable or a key, the count holds
    p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_RUN && !mc_en && !svc) |=> $stable(cnt_q));

    // R3: a running count stays below the active limit
    p_count_below_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_RUN) |-> (cnt_q < limit));

    // R4: a key while running restarts from zero
    p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_RUN && svc) |=> (state_q == WD_RUN && cnt_q == '0));

    // R5: the active limit cannot change mid-count
    p_limit_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_RUN && !svc) |=> $stable(limit));

    // R7: a reset pulse starts only from an armed count
    p_pulse_from_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> ($past(state_q) == WD_RUN));

    // R8: nothing disarms a running watchdog directly
    p_no_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_RUN) |=> (state_q != WD_OFF));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR   = 'hA6,
    parameter logic [ADDR_W-1:0] PRESC_ADDR = 'hA7,
    parameter bit                HAS_PRESC  = 1'b1,
    parameter int                BASE_EXP   = 14,
    parameter int                SEL_W      = 3,
    parameter int                PULSE_LEN  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sfr_we,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic [7:0]        sfr_wdata,
    input  logic              mc_en,
    output logic              wdt_rst_o
);
    localparam int CNT_W = HAS_PRESC ? (BASE_EXP + (1 << SEL_W) - 1) : BASE_EXP;

    logic             key_ok;
    logic             load;
    logic [SEL_W-1:0] sel;

    kwdt_key_fsm #(.ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR)) u_key (
        .clk(clk), .rst_n(rst_n), .wr_en(sfr_we), .wr_addr(sfr_addr),
        .wr_data(sfr_wdata), .key_ok(key_ok)
    );

    kwdt_timeout_sel #(.ADDR_W(ADDR_W), .PRESC_ADDR(PRESC_ADDR), .SEL_W(SEL_W),
                       .HAS_PRESC(HAS_PRESC)) u_sel (
        .clk(clk), .rst_n(rst_n), .wr_en(sfr_we), .wr_addr(sfr_addr),
        .wr_data(sfr_wdata), .load(load), .sel_o(sel)
    );

    kwdt_core #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W), .CNT_W(CNT_W),
                .PULSE_LEN(PULSE_LEN)) u_core (
        .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .svc(key_ok), .sel(sel),
        .load(load), .rst_req(wdt_rst_o)
    );
endmodule

// File: tb/tb_keyed_watchdog.sv
`timescale 1ns/1ps
module tb_keyed_watchdog;
    localparam int BASE_EXP  = 4;
    localparam int PULSE_LEN = 3;
    localparam int T0        = (1 << BASE_EXP) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic       mc_en = 1'b1;
    logic       rst_a, rst_b;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    keyed_watchdog #(.HAS_PRESC(1'b1), .BASE_EXP(BASE_EXP), .PULSE_LEN(PULSE_LEN)) dut (
        .clk(clk), .rst_n(rst_n), .sfr_we(we), .sfr_addr(addr), .sfr_wdata(wdata),
        .mc_en(mc_en), .wdt_rst_o(rst_a));

    keyed_watchdog #(.HAS_PRESC(1'b0), .BASE_EXP(BASE_EXP), .PULSE_LEN(PULSE_LEN)) dut_fix (
        .clk(clk), .rst_n(rst_n), .sfr_we(we), .sfr_addr(addr), .sfr_wdata(wdata),
        .mc_en(mc_en), .wdt_rst_o(rst_b));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FIL-%s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; we = 1'b0; mc_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic key();
        wr(8'hA6, 8'h1E);
        wr(8'hA6, 8'hE1);
    endtask

    // cycles from now until each output is first seen high
    task automatic measure(output int na, output int nb);
        na = -1; nb = -1;
        for (int i = 1; i <= 5000; i++) begin
            @(negedge clk);
            if (na < 0 && rst_a) na = i;
            if (nb < 0 && rst_b) nb = i;
            if (na >= 0 && nb >= 0) break;
        end
    endtask

    task automatic measure_a(output int na);
        na = -1;
        for (int i = 1; i <= 5000; i++) begin
            @(negedge clk);
            if (rst_a) begin na = i; break; end
        end
    endtask

    task automatic quiet(input int cycles, input string req);
        int highs = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (rst_a) highs++;
        end
        chk(highs == 0, req, highs, 0);
    endtask

    task automatic t_reset();
        do_reset();
        chk(rst_a == 1'b0, "R9 output low after reset", int'(rst_a), 0);
        quiet(4 * T0, "R9 disarmed after reset");
    endtask

    task automatic t_arm_and_pulse();
        int na, w;
        do_reset();
        key();
        measure_a(na);
        chk(na == T0 + 1, "R1 R3 timeout after arm", na, T0 + 1);
        w = 1;
        while (rst_a) begin @(negedge clk); if (rst_a) w++; end
        chk(w == PULSE_LEN, "R7 pulse width", w, PULSE_LEN);
        quiet(4 * T0, "R7 no pulse after release");
    endtask

    task automatic t_bad_keys();
        int na;
        do_reset();
        wr(8'hA6, 8'h1E); wr(8'hA6, 8'h55); wr(8'hA6, 8'hE1);
        quiet(3 * T0, "R2 wrong second byte cancels");
        wr(8'hA6, 8'hE1);
        quiet(3 * T0, "R2 lone second byte ignored");
        wr(8'hA5, 8'h1E); wr(8'hA6, 8'hE1);
        quiet(3 * T0, "R2 first byte at other address");
        wr(8'hA6, 8'h1E); wr(8'hA7, 8'h00); wr(8'hA6, 8'hE1);
        measure_a(na);
        chk(na == T0 + 1, "R2 other-address write keeps pending key", na, T0 + 1);
        do_reset();
        wr(8'hA6, 8'h1E); wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
        measure_a(na);
        chk(na == T0 + 1, "R2 repeated first byte stays half", na, T0 + 1);
    endtask

    task automatic t_mc_en();
        int na;
        do_reset();
        mc_en = 1'b0;
        key();
        quiet(5 * T0, "R3 no count without enable");
        mc_en = 1'b1;
        measure_a(na);
        chk(na == T0, "R3 count only on enabled cycles", na, T0);
    endtask

    task automatic t_service();
        int na, highs;
        do_reset();
        key();
        highs = 0;
        for (int k = 0; k < 4; k++) begin
            repeat (T0 - 5) begin @(negedge clk); if (rst_a) highs++; end
            key();
        end
        chk(highs == 0, "R4 no pulse while serviced", highs, 0);
        measure_a(na);
        chk(na == T0 + 1, "R4 timeout measured from last key", na, T0 + 1);
    endtask

    task automatic t_presc();
        int na, nb;
        do_reset();
        wr(8'hA7, 8'hFA);
        key();
        measure(na, nb);
        chk(na == (1 << (BASE_EXP + 2)), "R5 selector 2 timeout", na, 1 << (BASE_EXP + 2));
        chk(nb == T0 + 1, "R6 fixed timeout ignores selector", nb, T0 + 1);
        do_reset();
        key();
        wr(8'hA7, 8'h03);
        measure_a(na);
        chk(na == T0, "R5 selector deferred mid-count", na, T0);
        while (rst_a) @(negedge clk);
        key();
        measure_a(na);
        chk(na == (1 << (BASE_EXP + 3)), "R5 selector applied at next key", na, 1 << (BASE_EXP + 3));
    endtask

    task automatic t_no_disarm();
        int na;
        do_reset();
        key();
        wr(8'hA6, 8'h1E); wr(8'hA6, 8'h00);
        measure_a(na);
        chk(na == T0 - 1, "R8 junk writes do not stop count", na, T0 - 1);
        key();
        quiet(4 * T0, "R8 key during pulse ignored");
    endtask

    initial begin
        t_reset();
        t_arm_and_pulse();
        t_bad_keys();
        t_mc_en();
        t_service();
        t_presc();
        t_no_disarm();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule